// File: doc/BRIEF.md
# Bit-Addressable Data Memory Unit

This unit is the data store of a small 8-bit controller core. It holds 48 general RAM bytes at addresses 0x00 to 0x2F. It also holds a 16-byte register window at 0x00F0 to 0x00FF. The two pointer registers B and X and the stack pointer SP are ordinary bytes inside that window, at 0xFE, 0xFC and 0xFD. One control byte lives at 0xE0. It has a sticky enable bit, three plain bits and four read-only bits. Every other address reads as zero and ignores writes.

Each cycle the core may issue one command. The command carries an opcode, an addressing mode, a pointer-update code, an 8-bit direct address, a 3-bit bit index and an 8-bit data byte. The address is taken from the command or from B, X or SP. When B or X supplies the address, that pointer can step up or down by one and is written back at the same clock edge. The operations are byte read, byte write, immediate load, decrement-and-test, bit set, bit clear and bit test.

The response appears on the cycle after the command. It gives the addressed byte as it stands after the operation, and a zero flag.

Top module: `dmu_top`

## Requirements
- R1: Byte writes to 0x00–0x2F and 0xF0–0xFF are stored and read back unchanged. Any address other than these and 0xE0 reads 0x00 and ignores writes.
- R2: An accepted command with op ≠ 0 gives rspValid=1 one cycle later, with rspData equal to the addressed byte after the operation. Op 0 (NOP) or cmdValid=0 gives rspValid=0. Op codes: 0 NOP, 1 READ, 2 WRITE, 3 LDI, 4 DEC, 5 BSET, 6 BCLR, 7 BTEST.
- R3: LDI stores cmdData only when the effective address is in the register window. Elsewhere it changes nothing.
- R4: DEC lowers a window byte by one, modulo 256. rspZero is 1 exactly when the result is 0. DEC outside the window changes nothing.
- R5: Mode codes are 0 direct, 1 via B, 2 via X and 3 via SP. An indirect effective address is the byte held at 0xFE (B), 0xFC (X) or 0xFD (SP).
- R6: Pointer-update codes are 0 none, 1 increment, 2 decrement and 3 none. They apply only in modes 1 and 2. The pointer steps modulo 256 and is written back at the same edge as the access. Direct and SP modes leave all pointers unchanged.
- R7: BSET and BCLR change only the bit chosen by cmdBit. BTEST leaves the byte unchanged and gives rspZero=1 exactly when that bit is 0.
- R8: At 0xE0, bits 7:4 read as 0 and ignore all writes. Bits 3:1 are ordinary read/write bits.
- R9: Bit 0 of 0xE0 is set by a WRITE whose data bit 0 is 1. Nothing but reset clears it again. BSET and BCLR on bit 0 are ignored.
- R10: Reset clears rspValid, rspData, rspZero and the control byte. General RAM and window contents are kept across reset.
- R11: When an indirect write targets the pointer that is being updated in the same command, the written data wins over the stepped pointer value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, asynchronous assert |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 3 | Operation code |
| cmdMode | input | 2 | Addressing mode |
| cmdPtr | input | 2 | Pointer post-update code |
| cmdAddr | input | 8 | Direct address |
| cmdBit | input | 3 | Bit index for bit operations |
| cmdData | input | 8 | Write / immediate data |
| rspValid | output | 1 | Response present |
| rspData | output | 8 | Addressed byte after the operation |
| rspZero | output | 1 | Zero flag (tested bit, or result byte) |

## Verification
The assertions assume that every command field is driven to a defined value whenever cmdValid is high. They also assume cmdValid stays low while reset is asserted. The stimulus follows both rules: it holds cmdValid low through every reset pulse and sets all fields before each edge.

The pointer write-back check covers only cycles without a pointer/data collision, so the bench tests the collision on its own. That test aims B at its own address. The sweeps walk every mapped and unmapped address, every bit index and both wrap points of the pointers.

// File: rtl/dmu_pkg.sv
package dmu_pkg;

  localparam int DMU_AW = 8;
  localparam int DMU_DW = 8;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_READ  = 3'd1,
    OP_WRITE = 3'd2,
    OP_LDI   = 3'd3,
    OP_DEC   = 3'd4,
    OP_BSET  = 3'd5,
    OP_BCLR  = 3'd6,
    OP_BTEST = 3'd7
  } dmuOp_e;

  typedef enum logic [1:0] {
    AM_DIRECT = 2'd0,
    AM_VIA_B  = 2'd1,
    AM_VIA_X  = 2'd2,
    AM_VIA_SP = 2'd3
  } dmuMode_e;

  typedef enum logic [1:0] {
    PU_NONE = 2'd0,
    PU_INC  = 2'd1,
    PU_DEC  = 2'd2,
    PU_RSVD = 2'd3
  } dmuPtrUpd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [DMU_AW-1:0] addr;
    logic              inGen;
    logic              inWin;
    logic              inCtrl;
    logic              doWrite;
    logic              doDec;
    logic              doSet;
    logic              doClr;
    logic              doTest;
    logic [2:0]        bitSel;
    logic              ptrWe;
    logic [DMU_AW-1:0] ptrAddr;
    logic [DMU_DW-1:0] ptrVal;
    logic              rsp;
  } dmuStrobe_t;

endpackage

// File: rtl/dmu_ctrl.sv
module dmu_ctrl
  import dmu_pkg::*;
#(
  parameter int          GEN_BYTES = 48,
  parameter logic [7:0]  WIN_BASE  = 8'hF0,
  parameter int          WIN_BYTES = 16,
  parameter logic [7:0]  CTRL_ADDR = 8'hE0,
  parameter logic [7:0]  B_ADDR    = 8'hFE,
  parameter logic [7:0]  X_ADDR    = 8'hFC
) (
  input  logic                cmdValid,
  input  logic [2:0]          cmdOp,
  input  logic [1:0]          cmdMode,
  input  logic [1:0]          cmdPtr,
  input  logic [DMU_AW-1:0]   cmdAddr,
  input  logic [2:0]          cmdBit,
  input  logic [DMU_DW-1:0]   ptrB,
  input  logic [DMU_DW-1:0]   ptrX,
  input  logic [DMU_DW-1:0]   ptrSp,
  output dmuStrobe_t          strobe
);

  localparam logic [DMU_AW-1:0] GEN_LIM = DMU_AW'(GEN_BYTES);
  localparam logic [DMU_AW-1:0] WIN_TOP = DMU_AW'(int'(WIN_BASE) + WIN_BYTES - 1);

  dmuOp_e            op;
  dmuMode_e          mode;
  dmuPtrUpd_e        upd;
  logic [DMU_AW-1:0] effAddr;
  logic              go;
  logic              inWin;
  logic              viaPtr;
  logic [DMU_DW-1:0] ptrBase;

  always_comb begin
    op   = dmuOp_e'(cmdOp);
    mode = dmuMode_e'(cmdMode);
    upd  = dmuPtrUpd_e'(cmdPtr);

    unique case (mode)
      AM_DIRECT: effAddr = cmdAddr;
      AM_VIA_B:  effAddr = ptrB;
      AM_VIA_X:  effAddr = ptrX;
      default:   effAddr = ptrSp;
    endcase

    go     = cmdValid && (op != OP_NOP);
    inWin  = (effAddr >= WIN_BASE) && (effAddr <= WIN_TOP);
    viaPtr = (mode == AM_VIA_B) || (mode == AM_VIA_X);
    ptrBase = (mode == AM_VIA_B) ? ptrB : ptrX;

    strobe         = '0;
    strobe.addr    = effAddr;
    strobe.inGen   = effAddr < GEN_LIM;
    strobe.inWin   = inWin;
    strobe.inCtrl  = effAddr == CTRL_ADDR;
    strobe.bitSel  = cmdBit;
    strobe.rsp     = go;
    strobe.doWrite = go && ((op == OP_WRITE) || ((op == OP_LDI) && inWin));
    strobe.doDec   = go && (op == OP_DEC) && inWin;
    strobe.doSet   = go && (op == OP_BSET);
    strobe.doClr   = go && (op == OP_BCLR);
    strobe.doTest  = go && (op == OP_BTEST);

    if (go && viaPtr && ((upd == PU_INC) || (upd == PU_DEC))) begin
      strobe.ptrWe   = 1'b1;
      strobe.ptrAddr = (mode == AM_VIA_B) ? B_ADDR : X_ADDR;
      strobe.ptrVal  = (upd == PU_INC) ? ptrBase + 8'd1 : ptrBase - 8'd1;
    end
  end

endmodule

// File: rtl/dmu_dpath.sv
module dmu_dpath
  import dmu_pkg::*;
#(
  parameter int          GEN_BYTES = 48,
  parameter int          WIN_BYTES = 16,
  parameter logic [7:0]  B_ADDR    = 8'hFE,
  parameter logic [7:0]  X_ADDR    = 8'hFC,
  parameter logic [7:0]  SP_ADDR   = 8'hFD
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmuStrobe_t        strobe,
  input  logic [DMU_DW-1:0] wrData,
  output logic [DMU_DW-1:0] ptrB,
  output logic [DMU_DW-1:0] ptrX,
  output logic [DMU_DW-1:0] ptrSp,
  output logic              rspValid,
  output logic [DMU_DW-1:0] rspData,
  output logic              rspZero
);

  localparam int GEN_AW  = $clog2(GEN_BYTES);
  localparam int WIN_AW  = $clog2(WIN_BYTES);
  localparam int CTRL_W  = 4;  // bit0 sticky, bits 3:1 plain, upper bits read-only zero
  localparam logic [WIN_AW-1:0] B_IDX  = B_ADDR[WIN_AW-1:0];
  localparam logic [WIN_AW-1:0] X_IDX  = X_ADDR[WIN_AW-1:0];
  localparam logic [WIN_AW-1:0] SP_IDX = SP_ADDR[WIN_AW-1:0];

  logic [DMU_DW-1:0] genMem [GEN_BYTES];
  logic [DMU_DW-1:0] winMem [WIN_BYTES];
  logic [CTRL_W-1:0] ctrlBits;
  logic [CTRL_W-1:0] ctrlNext;
  logic              ctrlWe;

  logic [GEN_AW-1:0] genIdx;
  logic [WIN_AW-1:0] winIdx;
  logic [WIN_AW-1:0] ptrIdx;
  logic [DMU_DW-1:0] curByte;
  logic [DMU_DW-1:0] bitMask;
  logic [DMU_DW-1:0] modByte;
  logic [DMU_DW-1:0] postByte;
  logic              memWe;
  logic              armed;

  assign genIdx = strobe.addr[GEN_AW-1:0];
  assign winIdx = strobe.addr[WIN_AW-1:0];
  assign ptrIdx = strobe.ptrAddr[WIN_AW-1:0];

  assign ptrB  = winMem[B_IDX];
  assign ptrX  = winMem[X_IDX];
  assign ptrSp = winMem[SP_IDX];

  always_comb begin
    if (strobe.inGen)       curByte = genMem[genIdx];
    else if (strobe.inWin)  curByte = winMem[winIdx];
    else if (strobe.inCtrl) curByte = {{(DMU_DW-CTRL_W){1'b0}}, ctrlBits};
    else                    curByte = '0;
  end

  always_comb begin
    bitMask = 8'b1 << strobe.bitSel;
    if (strobe.doWrite)     modByte = wrData;
    else if (strobe.doDec)  modByte = curByte - 8'd1;
    else if (strobe.doSet)  modByte = curByte | bitMask;
    else if (strobe.doClr)  modByte = curByte & ~bitMask;
    else                    modByte = curByte;
    memWe = strobe.doWrite | strobe.doDec | strobe.doSet | strobe.doClr;
  end

  // control byte: upper bits dropped, bit0 only ever rises on a byte write
  always_comb begin
    ctrlWe             = strobe.inCtrl && (strobe.doWrite | strobe.doSet | strobe.doClr);
    ctrlNext[CTRL_W-1:1] = modByte[CTRL_W-1:1];
    ctrlNext[0]        = ctrlBits[0] | (strobe.doWrite & wrData[0]);
    if (!ctrlWe) ctrlNext = ctrlBits;
  end

  always_comb begin
    if (strobe.inCtrl)                     postByte = {{(DMU_DW-CTRL_W){1'b0}}, ctrlNext};
    else if (strobe.inGen || strobe.inWin) postByte = modByte;
    else                                   postByte = '0;
  end

  // general RAM: not reset, contents survive reset
  always_ff @(posedge clk) begin
    if (memWe && strobe.inGen) genMem[genIdx] <= modByte;
  end

  // register window: pointer write-back first, data write overrides on collision
  always_ff @(posedge clk) begin
    if (strobe.ptrWe)          winMem[ptrIdx] <= strobe.ptrVal;
    if (memWe && strobe.inWin) winMem[winIdx] <= modByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlBits <= '0;
    else       ctrlBits <= ctrlNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
      rspZero  <= 1'b0;
      armed    <= 1'b0;
    end else begin
      armed    <= 1'b1;
      rspValid <= strobe.rsp;
      if (strobe.rsp) begin
        rspData <= postByte;
        rspZero <= strobe.doTest ? ~curByte[strobe.bitSel] : (postByte == '0);
      end
    end
  end

  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (rspValid == $past(strobe.rsp)));

  assert_dec_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(strobe.doDec) |-> (rspData == $past(curByte) - 8'd1)
      && (rspZero == (rspData == 8'd0)));

  assert_ptr_writeback_R6: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(strobe.ptrWe) && !$past(memWe && strobe.inWin && (winIdx == ptrIdx))
      |-> winMem[$past(ptrIdx)] == $past(strobe.ptrVal));

  assert_test_keeps_R7: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(strobe.doTest) |-> (rspData == $past(curByte))
      && (rspZero == !$past(curByte[strobe.bitSel])));

  assert_ro_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(strobe.rsp && strobe.inCtrl) |-> rspData[7:4] == 4'd0);

  assert_once_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(ctrlBits[0]) |-> ctrlBits[0]);

endmodule

// File: rtl/dmu_top.sv
module dmu_top
  import dmu_pkg::*;
#(
  parameter int          GEN_BYTES = 48,
  parameter logic [7:0]  WIN_BASE  = 8'hF0,
  parameter int          WIN_BYTES = 16,
  parameter logic [7:0]  CTRL_ADDR = 8'hE0,
  parameter logic [7:0]  B_ADDR    = 8'hFE,
  parameter logic [7:0]  X_ADDR    = 8'hFC,
  parameter logic [7:0]  SP_ADDR   = 8'hFD
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  input  logic [1:0] cmdMode,
  input  logic [1:0] cmdPtr,
  input  logic [7:0] cmdAddr,
  input  logic [2:0] cmdBit,
  input  logic [7:0] cmdData,
  output logic       rspValid,
  output logic [7:0] rspData,
  output logic       rspZero
);

  dmuStrobe_t        strobe;
  logic [DMU_DW-1:0] ptrB;
  logic [DMU_DW-1:0] ptrX;
  logic [DMU_DW-1:0] ptrSp;

  dmu_ctrl #(
    .GEN_BYTES (GEN_BYTES),
    .WIN_BASE  (WIN_BASE),
    .WIN_BYTES (WIN_BYTES),
    .CTRL_ADDR (CTRL_ADDR),
    .B_ADDR    (B_ADDR),
    .X_ADDR    (X_ADDR)
  ) u_ctrl (
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .cmdMode  (cmdMode),
    .cmdPtr   (cmdPtr),
    .cmdAddr  (cmdAddr),
    .cmdBit   (cmdBit),
    .ptrB     (ptrB),
    .ptrX     (ptrX),
    .ptrSp    (ptrSp),
    .strobe   (strobe)
  );

  dmu_dpath #(
    .GEN_BYTES (GEN_BYTES),
    .WIN_BYTES (WIN_BYTES),
    .B_ADDR    (B_ADDR),
    .X_ADDR    (X_ADDR),
    .SP_ADDR   (SP_ADDR)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (cmdData),
    .ptrB     (ptrB),
    .ptrX     (ptrX),
    .ptrSp    (ptrSp),
    .rspValid (rspValid),
    .rspData  (rspData),
    .rspZero  (rspZero)
  );

endmodule

// File: tb/dmu_top_tb.sv
module dmu_top_tb;

  localparam logic [2:0] NOP = 3'd0, RD = 3'd1, WR = 3'd2, LDI = 3'd3,
                         DEC = 3'd4, BSET = 3'd5, BCLR = 3'd6, BTST = 3'd7;
  localparam logic [1:0] DIR = 2'd0, VB = 2'd1, VX = 2'd2, VSP = 2'd3;
  localparam logic [1:0] PN = 2'd0, PI = 2'd1, PD = 2'd2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [2:0] cmdOp = '0;
  logic [1:0] cmdMode = '0;
  logic [1:0] cmdPtr = '0;
  logic [7:0] cmdAddr = '0;
  logic [2:0] cmdBit = '0;
  logic [7:0] cmdData = '0;
  logic       rspValid;
  logic [7:0] rspData;
  logic       rspZero;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [7:0] gotData;
  logic       gotZero;
  logic       gotValid;

  always #5 clk = ~clk;

  dmu_top u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdMode(cmdMode),
    .cmdPtr(cmdPtr), .cmdAddr(cmdAddr), .cmdBit(cmdBit), .cmdData(cmdData),
    .rspValid(rspValid), .rspData(rspData), .rspZero(rspZero)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // called at a negedge; returns at the next negedge with the response captured
  task automatic issue(input logic [2:0] op, input logic [1:0] mode, input logic [1:0] pu,
                       input logic [7:0] addr, input logic [2:0] bt, input logic [7:0] d);
    cmdValid = 1'b1; cmdOp = op; cmdMode = mode; cmdPtr = pu;
    cmdAddr = addr; cmdBit = bt; cmdData = d;
    @(negedge clk);
    gotData = rspData; gotZero = rspZero; gotValid = rspValid;
    cmdValid = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    issue(WR, DIR, PN, a, 3'd0, d);
  endtask

  task automatic rdChk(input string req, input logic [7:0] a, input logic [7:0] exp);
    issue(RD, DIR, PN, a, 3'd0, 8'h00);
    check(req, gotData, exp);
  endtask

  function automatic logic [7:0] genPat(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  task automatic pulseReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 rspValid", {7'd0, rspValid}, 8'h00);
    check("R10 rspData", rspData, 8'h00);
    check("R10 rspZero", {7'd0, rspZero}, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
  end

  initial begin
    pulseReset();

    // R1: general and window bytes
    for (int a = 0; a < 48; a++) wr(8'(a), genPat(a));
    for (int w = 0; w < 16; w++) wr(8'(8'hF0 + w), 8'((w * 13 + 1) ^ 8'h5A));
    for (int a = 0; a < 48; a++) begin
      issue(RD, DIR, PN, 8'(a), 3'd0, 8'h00);
      check("R1 general readback", gotData, genPat(a));
      check("R2 rspValid after read", {7'd0, gotValid}, 8'h01);
    end
    for (int w = 0; w < 16; w++) rdChk("R1 window readback", 8'(8'hF0 + w), 8'((w * 13 + 1) ^ 8'h5A));
    for (int a = 8'h30; a < 8'hF0; a++) begin
      if (a != 8'hE0) begin
        wr(8'(a), 8'hA5);
        check("R1 unmapped write resp", gotData, 8'h00);
        rdChk("R1 unmapped read", 8'(a), 8'h00);
      end
    end

    // R2: NOP gives no response
    issue(NOP, DIR, PN, 8'h01, 3'd0, 8'h00);
    check("R2 nop no rspValid", {7'd0, gotValid}, 8'h00);
    @(negedge clk);
    check("R2 idle no rspValid", {7'd0, rspValid}, 8'h00);

    // R3: immediate load only in window
    for (int w = 0; w < 16; w++) issue(LDI, DIR, PN, 8'(8'hF0 + w), 3'd0, 8'(8'h80 + w));
    for (int w = 0; w < 16; w++) rdChk("R3 ldi window", 8'(8'hF0 + w), 8'(8'h80 + w));
    issue(LDI, DIR, PN, 8'h10, 3'd0, 8'hEE);
    rdChk("R3 ldi outside ignored", 8'h10, genPat(16));

    // R4: decrement and test
    issue(LDI, DIR, PN, 8'hF3, 3'd0, 8'h03);
    for (int k = 2; k >= -1; k--) begin
      issue(DEC, DIR, PN, 8'hF3, 3'd0, 8'h00);
      check("R4 dec value", gotData, 8'(k & 255));
      check("R4 dec zero", {7'd0, gotZero}, {7'd0, k == 0});
    end
    issue(DEC, DIR, PN, 8'h11, 3'd0, 8'h00);
    check("R4 dec outside resp", gotData, genPat(17));
    rdChk("R4 dec outside ignored", 8'h11, genPat(17));

    // R5, R6: indirect addressing and pointer stepping
    wr(8'hFE, 8'h05);
    for (int i = 0; i < 3; i++) issue(WR, VB, PI, 8'h00, 3'd0, 8'(8'h30 + i));
    for (int i = 0; i < 3; i++) rdChk("R5 via B write", 8'(5 + i), 8'(8'h30 + i));
    rdChk("R6 B incremented", 8'hFE, 8'h08);
    wr(8'hFC, 8'h00);
    issue(WR, VX, PD, 8'h00, 3'd0, 8'h99);
    rdChk("R5 via X write", 8'h00, 8'h99);
    rdChk("R6 X wraps down", 8'hFC, 8'hFF);
    wr(8'hFE, 8'hFF);
    issue(RD, VB, PI, 8'h00, 3'd0, 8'h00);
    check("R5 via B read window", gotData, 8'h8F);
    rdChk("R6 B wraps up", 8'hFE, 8'h00);
    issue(RD, VB, PN, 8'h00, 3'd0, 8'h00);
    check("R5 via B read general", gotData, 8'h99);
    wr(8'hFD, 8'h20);
    issue(RD, VSP, PI, 8'h00, 3'd0, 8'h00);
    check("R5 via SP read", gotData, genPat(32));
    rdChk("R6 SP not stepped", 8'hFD, 8'h20);
    rdChk("R6 B unchanged by SP mode", 8'hFE, 8'h00);

    // R7: bit operations
    for (int b = 0; b < 8; b++) begin
      wr(8'h2A, 8'h00);
      issue(BSET, DIR, PN, 8'h2A, 3'(b), 8'h00);
      check("R7 bset", gotData, 8'(1 << b));
      issue(BTST, DIR, PN, 8'h2A, 3'(b), 8'h00);
      check("R7 btest set bit", {gotZero, gotData[6:0]}, {1'b0, 7'((1 << b) & 127)});
      issue(BTST, DIR, PN, 8'h2A, 3'((b + 1) % 8), 8'h00);
      check("R7 btest clear bit", {7'd0, gotZero}, 8'h01);
      rdChk("R7 btest no change", 8'h2A, 8'(1 << b));
      wr(8'h2A, 8'hFF);
      issue(BCLR, DIR, PN, 8'h2A, 3'(b), 8'h00);
      check("R7 bclr", gotData, 8'(~(1 << b)));
    end

    // R8, R9: control byte
    rdChk("R8 ctrl after reset", 8'hE0, 8'h00);
    wr(8'hE0, 8'hFE);
    rdChk("R8 ctrl ro bits", 8'hE0, 8'h0E);
    issue(BSET, DIR, PN, 8'hE0, 3'd0, 8'h00);
    check("R9 bset on sticky ignored", gotData, 8'h0E);
    issue(BSET, DIR, PN, 8'hE0, 3'd7, 8'h00);
    check("R8 bset on ro ignored", gotData, 8'h0E);
    issue(BCLR, DIR, PN, 8'hE0, 3'd1, 8'h00);
    check("R8 bclr plain bit", gotData, 8'h0C);
    wr(8'hE0, 8'h01);
    rdChk("R9 sticky set by write", 8'hE0, 8'h01);
    wr(8'hE0, 8'h00);
    rdChk("R9 sticky kept on write 0", 8'hE0, 8'h01);
    issue(BCLR, DIR, PN, 8'hE0, 3'd0, 8'h00);
    check("R9 bclr on sticky ignored", gotData, 8'h01);
    wr(8'hE0, 8'hFF);
    rdChk("R8 ctrl full write", 8'hE0, 8'h0F);

    // R11: data write beats pointer step
    wr(8'hFE, 8'hFE);
    issue(WR, VB, PI, 8'h00, 3'd0, 8'h42);
    rdChk("R11 collision data wins", 8'hFE, 8'h42);

    // R10: reset clears control, keeps RAM
    pulseReset();
    rdChk("R10 ctrl cleared", 8'hE0, 8'h00);
    rdChk("R10 general kept", 8'h05, 8'h30);
    rdChk("R10 window kept", 8'hF3, 8'hFF);

    summary();
  end

endmodule